// File: doc/BRIEF.md
# Two-way time transfer delay, offset and drift calculator

This block turns the four event timestamps of one two-way time exchange into the three numbers a clock servo needs: the mean path delay, the offset of the local (slave) clock against the remote (master) clock, and the relative frequency error between them. The four timestamps are the master's sync send time, the slave's sync receive time, the slave's delay-request send time and the master's delay-request receive time. Each one arrives on its own strobe as an unsigned seconds field plus a nanoseconds field. The block converts each timestamp to a signed 64-bit nanosecond count as it captures it.

The master send time can be delivered in two ways. It can come in the same cycle as the sync receive strobe (single-message delivery). It can also come later in a follow-up strobe that carries a sequence number, which must match the sequence number of the sync. Drift is measured from the current sample and the previously completed sample. It is computed with a sequential signed divider and given as a fixed-point fraction scaled by 2^32.

Results leave on a valid/ready handshake. While a result is pending or the divider is running, the block stops accepting timestamps.

Top module: `ptp_offset_calc`

## Requirements
- R1: Each captured timestamp is converted to nanoseconds as sec * 1,000,000,000 + ns. The forward difference A is slave receive minus master send, and the reverse difference B is master request receive minus slave request send.
- R2: `delay_o` equals (A + B) shifted arithmetically right by one bit, which rounds toward minus infinity.
- R3: `offset_o` equals (A - B) shifted arithmetically right by one bit, which rounds toward minus infinity. It is positive when the slave clock is ahead.
- R4: When an earlier sample has completed, Δ0 = master send minus the previous master send and Δ1 = slave receive minus the previous slave receive. `drift_o` is ((Δ1 - Δ0) * 2^32) / Δ1, truncated toward zero in 64-bit signed arithmetic, and `drift_vld_o` is 1. For the first sample after reset, `drift_vld_o` is 0 and `drift_o` is 0.
- R5: When an earlier sample exists and Δ1 is zero, the result has `drift_err_o` = 1, `drift_vld_o` = 0 and `drift_o` = 0, and no division is run.
- R6: With `two_step_i` = 0, the master send time is taken from `mts_sec_i`/`mts_ns_i` in the same cycle as `sync_vld_i`, and `mts_vld_i` is ignored.
- R7: With `two_step_i` = 1, no result is produced until a sync and then a follow-up (`mts_vld_i`) with an equal sequence number have both been captured. A follow-up that arrives with no sync held is ignored.
- R8: In two-step mode, a follow-up whose sequence number differs from the held sync discards the held sync. It also sets `mismatch_o`, which stays at 1 until reset. A discarded sync does not become the reference for the next drift.
- R9: `busy_o` is 1 while the divider runs. `in_ready_o` is 0 while the divider runs, while a result is pending, and while a full sample is being taken. Strobes are captured only when `in_ready_o` is 1.
- R10: While `out_valid_o` = 1 and `out_ready_i` = 0, all result outputs hold steady. Strobes presented in this period are not captured.
- R11: After reset, `out_valid_o` = 0, `busy_o` = 0, `mismatch_o` = 0 and `in_ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_step_i | input | 1 | 1 = master send time arrives in a later follow-up |
| sync_vld_i | input | 1 | Slave sync receive timestamp strobe |
| sync_seq_i | input | SEQ_W | Sequence number of the sync |
| sync_sec_i | input | SEC_W | Sync receive time, seconds |
| sync_ns_i | input | NS_W | Sync receive time, nanoseconds |
| mts_vld_i | input | 1 | Follow-up strobe (two-step mode only) |
| mts_seq_i | input | SEQ_W | Sequence number of the follow-up |
| mts_sec_i | input | SEC_W | Master send time, seconds |
| mts_ns_i | input | NS_W | Master send time, nanoseconds |
| dreq_vld_i | input | 1 | Slave request send timestamp strobe |
| dreq_sec_i | input | SEC_W | Request send time, seconds |
| dreq_ns_i | input | NS_W | Request send time, nanoseconds |
| dresp_vld_i | input | 1 | Master request receive timestamp strobe |
| dresp_sec_i | input | SEC_W | Request receive time, seconds |
| dresp_ns_i | input | NS_W | Request receive time, nanoseconds |
| in_ready_o | output | 1 | Timestamp strobes are accepted |
| busy_o | output | 1 | Drift divider running |
| mismatch_o | output | 1 | Sticky follow-up sequence mismatch |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer accepts the result |
| delay_o | output | 64 | Mean path delay, signed ns |
| offset_o | output | 64 | Slave minus master offset, signed ns |
| drift_o | output | 64 | Frequency error, signed, scaled by 2^32 |
| drift_vld_o | output | 1 | drift_o holds a computed value |
| drift_err_o | output | 1 | Δ1 was zero |

## Verification
The exchanges use both delivery modes. One has odd negative A - B, which separates floor rounding from truncation. Drift values of both signs show that the divider's sign handling is independent of the magnitude path. A repeated slave receive time triggers the zero-divisor path. A mismatched follow-up, and a follow-up with no sync held, show that only a matching pair completes a sample and that the discarded sync does not become the drift reference. A result held under back-pressure, with strobes presented during the hold, tells stable outputs apart from leaked captures: a later sample stays incomplete unless its request timestamps are sent again.

// File: rtl/ptp_calc_pkg.sv
package ptp_calc_pkg;

  localparam int VAL_W = 64;
  typedef logic signed [VAL_W-1:0] ns_t;

  typedef enum logic [1:0] {
    CALC_IDLE = 2'd0,
    CALC_DIV  = 2'd1,
    CALC_OUT  = 2'd2
  } calc_state_t;

  // seconds/nanoseconds pair to a signed nanosecond count
  function automatic ns_t ts_to_ns(input logic [VAL_W-1:0] sec, input logic [VAL_W-1:0] nsec);
    logic [VAL_W-1:0] sum;
    sum = sec * 64'd1000000000 + nsec;
    return $signed(sum);
  endfunction

  // halving that rounds toward minus infinity
  function automatic ns_t half_floor(input ns_t x);
    return x >>> 1;
  endfunction

endpackage

// File: rtl/ptp_stamp_collect.sv
module ptp_stamp_collect
  import ptp_calc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_en,
  input  logic             take,
  input  logic             two_step,
  input  logic             sync_vld,
  input  logic [SEQ_W-1:0] sync_seq,
  input  logic [SEC_W-1:0] sync_sec,
  input  logic [NS_W-1:0]  sync_ns,
  input  logic             mts_vld,
  input  logic [SEQ_W-1:0] mts_seq,
  input  logic [SEC_W-1:0] mts_sec,
  input  logic [NS_W-1:0]  mts_ns,
  input  logic             dreq_vld,
  input  logic [SEC_W-1:0] dreq_sec,
  input  logic [NS_W-1:0]  dreq_ns,
  input  logic             dresp_vld,
  input  logic [SEC_W-1:0] dresp_sec,
  input  logic [NS_W-1:0]  dresp_ns,
  output logic             full,
  output ns_t              m_tx,
  output ns_t              s_rx,
  output ns_t              s_req,
  output ns_t              m_req,
  output logic             mismatch,
  output logic             fu_drop
);

  logic             have_mtx, have_srx, have_sreq, have_mreq;
  logic [SEQ_W-1:0] held_seq;
  logic             fu_match;

  // named events for assertions and readability
  assign fu_match = accept_en && two_step && mts_vld && have_srx && (mts_seq == held_seq);
  assign fu_drop  = accept_en && two_step && mts_vld && have_srx && (mts_seq != held_seq);
  assign full     = have_mtx && have_srx && have_sreq && have_mreq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_mtx  <= 1'b0;
      have_srx  <= 1'b0;
      have_sreq <= 1'b0;
      have_mreq <= 1'b0;
      held_seq  <= '0;
      m_tx      <= '0;
      s_rx      <= '0;
      s_req     <= '0;
      m_req     <= '0;
      mismatch  <= 1'b0;
    end else if (take) begin
      have_mtx  <= 1'b0;
      have_srx  <= 1'b0;
      have_sreq <= 1'b0;
      have_mreq <= 1'b0;
    end else if (accept_en) begin
      if (fu_match) begin
        m_tx     <= ts_to_ns(64'(mts_sec), 64'(mts_ns));
        have_mtx <= 1'b1;
      end
      if (fu_drop) begin
        have_srx <= 1'b0;
        have_mtx <= 1'b0;
        mismatch <= 1'b1;
      end
      // a new sync overrides anything above for the same slots
      if (sync_vld) begin
        s_rx     <= ts_to_ns(64'(sync_sec), 64'(sync_ns));
        held_seq <= sync_seq;
        have_srx <= 1'b1;
        if (!two_step) begin
          m_tx     <= ts_to_ns(64'(mts_sec), 64'(mts_ns));
          have_mtx <= 1'b1;
        end else begin
          have_mtx <= 1'b0;
        end
      end
      if (dreq_vld) begin
        s_req     <= ts_to_ns(64'(dreq_sec), 64'(dreq_ns));
        have_sreq <= 1'b1;
      end
      if (dresp_vld) begin
        m_req     <= ts_to_ns(64'(dresp_sec), 64'(dresp_ns));
        have_mreq <= 1'b1;
      end
    end
  end

  assert_sticky_mismatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch);
  assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_drop && !sync_vld) |=> !full);
  assert_no_capture_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_en && !take) |=> $stable(full) && $stable(s_rx) && $stable(m_req));

endmodule

// File: rtl/ptp_drift_div.sv
module ptp_drift_div #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] quo
);

  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     work_q;   // dividend shifting out, quotient shifting in
  logic [W-1:0]     rem_q;
  logic [W-1:0]     dmag_q;
  logic             neg_q;

  logic [W-1:0] num_mag, den_mag;
  logic [W:0]   trial, diff;
  logic         ge;
  logic [W-1:0] next_rem, next_work;

  assign num_mag   = num[W-1] ? (~num + 1'b1) : num;
  assign den_mag   = den[W-1] ? (~den + 1'b1) : den;
  assign trial     = {rem_q, work_q[W-1]};
  assign diff      = trial - {1'b0, dmag_q};
  assign ge        = trial >= {1'b0, dmag_q};
  assign next_rem  = ge ? diff[W-1:0] : trial[W-1:0];
  assign next_work = {work_q[W-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      work_q <= '0;
      rem_q  <= '0;
      dmag_q <= '0;
      neg_q  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      quo    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        work_q <= num_mag;
        dmag_q <= den_mag;
        rem_q  <= '0;
        neg_q  <= num[W-1] ^ den[W-1];
        cnt_q  <= CNT_W'(W);
        busy   <= 1'b1;
      end else if (busy) begin
        work_q <= next_work;
        rem_q  <= next_rem;
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= neg_q ? $signed(~next_work + 1'b1) : $signed(next_work);
        end
      end
    end
  end

  assert_done_follows_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_busy_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));

endmodule

// File: rtl/ptp_offset_calc.sv
module ptp_offset_calc
  import ptp_calc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int SEQ_W      = 16,
  parameter int DRIFT_FRAC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_step_i,
  input  logic             sync_vld_i,
  input  logic [SEQ_W-1:0] sync_seq_i,
  input  logic [SEC_W-1:0] sync_sec_i,
  input  logic [NS_W-1:0]  sync_ns_i,
  input  logic             mts_vld_i,
  input  logic [SEQ_W-1:0] mts_seq_i,
  input  logic [SEC_W-1:0] mts_sec_i,
  input  logic [NS_W-1:0]  mts_ns_i,
  input  logic             dreq_vld_i,
  input  logic [SEC_W-1:0] dreq_sec_i,
  input  logic [NS_W-1:0]  dreq_ns_i,
  input  logic             dresp_vld_i,
  input  logic [SEC_W-1:0] dresp_sec_i,
  input  logic [NS_W-1:0]  dresp_ns_i,
  output logic             in_ready_o,
  output logic             busy_o,
  output logic             mismatch_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [63:0]      delay_o,
  output logic [63:0]      offset_o,
  output logic [63:0]      drift_o,
  output logic             drift_vld_o,
  output logic             drift_err_o
);

  calc_state_t state_q;
  logic        full, take, accept_en, fu_drop;
  ns_t         m_tx, s_rx, s_req, m_req;
  ns_t         prev_m_q, prev_s_q;
  logic        have_prev_q;
  ns_t         fwd, rev, d0, d1, drift_num;
  logic        div_start, div_busy, div_done;
  ns_t         div_quo;
  ns_t         delay_q, offset_q, drift_q;
  logic        dvld_q, derr_q;

  assign accept_en = (state_q == CALC_IDLE) && !full;
  assign take      = (state_q == CALC_IDLE) && full;
  assign in_ready_o = accept_en;

  ptp_stamp_collect #(.SEC_W(SEC_W), .NS_W(NS_W), .SEQ_W(SEQ_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_en (accept_en),
    .take      (take),
    .two_step  (two_step_i),
    .sync_vld  (sync_vld_i),
    .sync_seq  (sync_seq_i),
    .sync_sec  (sync_sec_i),
    .sync_ns   (sync_ns_i),
    .mts_vld   (mts_vld_i),
    .mts_seq   (mts_seq_i),
    .mts_sec   (mts_sec_i),
    .mts_ns    (mts_ns_i),
    .dreq_vld  (dreq_vld_i),
    .dreq_sec  (dreq_sec_i),
    .dreq_ns   (dreq_ns_i),
    .dresp_vld (dresp_vld_i),
    .dresp_sec (dresp_sec_i),
    .dresp_ns  (dresp_ns_i),
    .full      (full),
    .m_tx      (m_tx),
    .s_rx      (s_rx),
    .s_req     (s_req),
    .m_req     (m_req),
    .mismatch  (mismatch_o),
    .fu_drop   (fu_drop)
  );

  assign fwd       = s_rx - m_tx;
  assign rev       = m_req - s_req;
  assign d0        = m_tx - prev_m_q;
  assign d1        = s_rx - prev_s_q;
  assign drift_num = (d1 - d0) <<< DRIFT_FRAC;
  assign div_start = take && have_prev_q && (d1 != '0);

  ptp_drift_div #(.W(VAL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (drift_num),
    .den   (d1),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  assign busy_o = div_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= CALC_IDLE;
      prev_m_q    <= '0;
      prev_s_q    <= '0;
      have_prev_q <= 1'b0;
      delay_q     <= '0;
      offset_q    <= '0;
      drift_q     <= '0;
      dvld_q      <= 1'b0;
      derr_q      <= 1'b0;
    end else begin
      unique case (state_q)
        CALC_IDLE: if (take) begin
          delay_q     <= half_floor(fwd + rev);
          offset_q    <= half_floor(fwd - rev);
          prev_m_q    <= m_tx;
          prev_s_q    <= s_rx;
          have_prev_q <= 1'b1;
          drift_q     <= '0;
          dvld_q      <= 1'b0;
          derr_q      <= have_prev_q && (d1 == '0);
          state_q     <= div_start ? CALC_DIV : CALC_OUT;
        end
        CALC_DIV: if (div_done) begin
          drift_q <= div_quo;
          dvld_q  <= 1'b1;
          state_q <= CALC_OUT;
        end
        CALC_OUT: if (out_ready_i) state_q <= CALC_IDLE;
        default: state_q <= CALC_IDLE;
      endcase
    end
  end

  assign out_valid_o = (state_q == CALC_OUT);
  assign delay_o     = delay_q;
  assign offset_o    = offset_q;
  assign drift_o     = drift_q;
  assign drift_vld_o = dvld_q;
  assign drift_err_o = derr_q;

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(delay_o) && $stable(offset_o)
      && $stable(drift_o) && $stable(drift_vld_o) && $stable(drift_err_o));
  assert_busy_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready_o && !out_valid_o);
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && drift_err_o) |-> (drift_o == 64'd0) && !drift_vld_o);
  assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !(drift_vld_o && drift_err_o));

endmodule

// File: tb/ptp_offset_calc_test.sv
`timescale 1ns/1ps
module ptp_offset_calc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        two_step_i = 1'b0;
  logic        sync_vld_i = 1'b0, mts_vld_i = 1'b0, dreq_vld_i = 1'b0, dresp_vld_i = 1'b0;
  logic [15:0] sync_seq_i = '0, mts_seq_i = '0;
  logic [31:0] sync_sec_i = '0, mts_sec_i = '0, dreq_sec_i = '0, dresp_sec_i = '0;
  logic [29:0] sync_ns_i = '0, mts_ns_i = '0, dreq_ns_i = '0, dresp_ns_i = '0;
  logic        out_ready_i = 1'b0;
  logic        in_ready_o, busy_o, mismatch_o, out_valid_o, drift_vld_o, drift_err_o;
  logic [63:0] delay_o, offset_o, drift_o;

  always #2.5 clk = ~clk;

  ptp_offset_calc uut (.*);

  typedef struct {
    longint dly; longint off; longint dft; bit dv; bit de; string tag;
  } exp_t;
  exp_t   sb[$];
  int     checks = 0, errors = 0;
  bit     hold_rdy = 1'b0;
  longint prev_m = 0, prev_s = 0;
  bit     have_prev = 1'b0;
  int     got = 0;

  function automatic longint tns(input longint s, input longint n);
    return s * 64'sd1000000000 + n;
  endfunction

  function automatic longint fl2(input longint x);
    return x / 2 - ((x < 0 && (x % 2) != 0) ? 1 : 0);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // expected result for one complete sample
  task automatic expect_sample(input longint t1, input longint t2, input longint t3,
                               input longint t4, input string tag);
    exp_t e;
    longint a, b, m0, m1;
    a = t2 - t1;
    b = t4 - t3;
    e.dly = fl2(a + b);
    e.off = fl2(a - b);
    e.dft = 0; e.dv = 0; e.de = 0; e.tag = tag;
    if (have_prev) begin
      m0 = t1 - prev_m;
      m1 = t2 - prev_s;
      if (m1 == 0) e.de = 1;
      else begin
        e.dft = ((m1 - m0) * 64'sd4294967296) / m1;
        e.dv = 1;
      end
    end
    prev_m = t1; prev_s = t2; have_prev = 1;
    sb.push_back(e);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
  endtask

  task automatic send_sync(input int seq, input longint s, input longint n,
                           input longint ms, input longint mn);
    wait_ready();
    sync_vld_i = 1; sync_seq_i = 16'(seq); sync_sec_i = 32'(s); sync_ns_i = 30'(n);
    mts_sec_i = 32'(ms); mts_ns_i = 30'(mn);
    @(negedge clk); sync_vld_i = 0;
  endtask

  task automatic send_fu(input int seq, input longint s, input longint n);
    wait_ready();
    mts_vld_i = 1; mts_seq_i = 16'(seq); mts_sec_i = 32'(s); mts_ns_i = 30'(n);
    @(negedge clk); mts_vld_i = 0;
  endtask

  task automatic send_req(input longint s, input longint n);
    wait_ready();
    dreq_vld_i = 1; dreq_sec_i = 32'(s); dreq_ns_i = 30'(n);
    @(negedge clk); dreq_vld_i = 0;
  endtask

  task automatic send_resp(input longint s, input longint n);
    wait_ready();
    dresp_vld_i = 1; dresp_sec_i = 32'(s); dresp_ns_i = 30'(n);
    @(negedge clk); dresp_vld_i = 0;
  endtask

  task automatic wait_drained();
    while (sb.size() != 0 || out_valid_o) @(negedge clk);
  endtask

  // monitor: pops expected items and compares as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid_o && !hold_rdy) begin
        if (sb.size() == 0) begin
          chk("R10 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({"R2 delay ", e.tag}, $signed(delay_o), e.dly);
          chk({"R3 offset ", e.tag}, $signed(offset_o), e.off);
          chk({"R4 drift ", e.tag}, $signed(drift_o), e.dft);
          chk({"R4 drift_vld ", e.tag}, longint'(drift_vld_o), longint'(e.dv));
          chk({"R5 drift_err ", e.tag}, longint'(drift_err_o), longint'(e.de));
        end
        got++;
        out_ready_i = 1;
        @(negedge clk);
        out_ready_i = 0;
      end
    end
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint h_dly, h_off, h_dft;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", longint'(out_valid_o), 0);
    chk("R11 busy", longint'(busy_o), 0);
    chk("R11 mismatch", longint'(mismatch_o), 0);
    chk("R11 in_ready", longint'(in_ready_o), 1);

    // R6 one-step, first sample: R1 differences, no drift yet (R4)
    two_step_i = 0;
    expect_sample(tns(100, 500000000), tns(100, 500001300), tns(100, 500200000),
                  tns(100, 500201100), "ex1");
    send_sync(1, 100, 500001300, 100, 500000000);
    send_req(100, 500200000);
    send_resp(100, 500201100);
    wait_drained();

    // one-step, positive drift; check busy during division (R9)
    expect_sample(tns(101, 500000000), tns(101, 500001350), tns(101, 500300000),
                  tns(101, 500301000), "ex2");
    send_sync(2, 101, 500001350, 101, 500000000);
    send_req(101, 500300000);
    send_resp(101, 500301000);
    repeat (3) @(negedge clk);
    chk("R9 busy during divide", longint'(busy_o), 1);
    chk("R9 in_ready low while busy", longint'(in_ready_o), 0);
    wait_drained();

    // R7 two-step, odd negative A-B (floor rounding R3), negative drift
    two_step_i = 1;
    expect_sample(tns(102, 500000000), tns(102, 500000900), tns(102, 600000000),
                  tns(102, 600001401), "ex3");
    send_sync(3, 102, 500000900, 0, 0);
    send_fu(3, 102, 500000000);
    send_req(102, 600000000);
    send_resp(102, 600001401);
    wait_drained();

    // R8 mismatch discards the sync; R7 follow-up alone is ignored
    send_sync(5, 103, 123456789, 0, 0);
    send_fu(6, 103, 100000000);
    repeat (3) @(negedge clk);
    chk("R8 mismatch flag", longint'(mismatch_o), 1);
    send_req(103, 700000000);
    send_resp(103, 700000800);
    send_fu(7, 103, 500000000);
    repeat (20) @(negedge clk);
    chk("R7 no result without sync", longint'(out_valid_o), 0);
    expect_sample(tns(103, 500000000), tns(103, 500000700), tns(103, 700000000),
                  tns(103, 700000800), "ex4");
    send_sync(7, 103, 500000700, 0, 0);
    send_fu(7, 103, 500000000);
    wait_drained();
    chk("R8 mismatch sticky", longint'(mismatch_o), 1);

    // R5 zero slave interval
    two_step_i = 0;
    expect_sample(tns(104, 0), tns(103, 500000700), tns(104, 100000000),
                  tns(104, 100000500), "ex5");
    send_sync(8, 103, 500000700, 104, 0);
    send_req(104, 100000000);
    send_resp(104, 100000500);
    wait_drained();

    // R10 hold under back-pressure, strobes during hold ignored
    hold_rdy = 1;
    expect_sample(tns(105, 999999000), tns(106, 1000), tns(106, 2000000),
                  tns(106, 2003000), "ex6");
    send_sync(9, 106, 1000, 105, 999999000);
    send_req(106, 2000000);
    send_resp(106, 2003000);
    while (!out_valid_o) @(negedge clk);
    h_dly = $signed(delay_o); h_off = $signed(offset_o); h_dft = $signed(drift_o);
    dreq_vld_i = 1; dreq_sec_i = 32'd999; @(negedge clk); dreq_vld_i = 0;
    dresp_vld_i = 1; dresp_sec_i = 32'd999; @(negedge clk); dresp_vld_i = 0;
    repeat (10) @(negedge clk);
    chk("R10 valid held", longint'(out_valid_o), 1);
    chk("R10 in_ready low while pending", longint'(in_ready_o), 0);
    chk("R10 delay stable", $signed(delay_o), h_dly);
    chk("R10 offset stable", $signed(offset_o), h_off);
    chk("R10 drift stable", $signed(drift_o), h_dft);
    hold_rdy = 0;
    wait_drained();
    send_sync(10, 107, 1000, 106, 999999500);
    repeat (100) @(negedge clk);
    chk("R10 strobes during hold not captured", longint'(out_valid_o), 0);
    expect_sample(tns(106, 999999500), tns(107, 1000), tns(107, 5000000),
                  tns(107, 5001234), "ex7");
    send_req(107, 5000000);
    send_resp(107, 5001234);
    wait_drained();
    chk("R1 all results seen", longint'(got), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule